// File: doc/BRIEF.md
# ALU Status and Control Flags Register

This block sits beside a small 8/16-bit arithmetic unit and keeps its 16-bit flags word. When the arithmetic unit finishes an operation it presents both operands, a 3-bit operation code, the operand size, the raw result and the carry (or borrow) out, together with an update strobe. From these the block derives six condition flags: carry, parity, auxiliary (nibble) carry, zero, sign and overflow. It registers them, so the new values are visible from the next clock edge.

Three control flags sit in the same word: string direction, maskable-interrupt enable and single-step trap. The condition-flag update never touches them. They change only through dedicated set and clear commands, or through a full load of the whole word, which a restore from the stack would use. The block also gates an incoming maskable interrupt request with the enable flag.

Top module: `alu_flag_reg`

## Requirements
- R1: After reset the flags word reads 16'h0002: every flag is 0 and bit 1 is 1.
- R2: The layout of the flags word is carry bit 0, parity bit 2, auxiliary bit 4, zero bit 6, sign bit 7, trap bit 8, interrupt-enable bit 9, direction bit 10 and overflow bit 11. Bit 1 always reads 1 and bits 3, 5, 12 to 15 always read 0, including after a full load that writes 1s there.
- R3: The operation codes are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 increment and 6 decrement. For add and subtract the carry flag takes the carry/borrow input. Increment and decrement leave the carry flag unchanged. AND, OR and XOR clear it.
- R4: Parity is 1 when the low 8 bits of the result hold an even number of 1s, for both operand sizes.
- R5: The auxiliary flag is 1 when a carry or borrow crosses from bit 3 into bit 4, computed as operand A bit 4 XOR operand B bit 4 XOR result bit 4, with B taken as 1 for increment and decrement. Logical operations clear it.
- R6: With the size input 0 (byte), zero looks at result bits 7:0 and sign copies bit 7. With size 1 (word), zero looks at bits 15:0 and sign copies bit 15.
- R7: Overflow is 1 when the signed result leaves the range of the operand size. For add and increment this means both operands share a sign that differs from the result. For subtract and decrement it means the operands differ in sign and the result differs from operand A. Logical operations clear it.
- R8: Each control flag has a set and a clear command. A command takes effect at the next edge. When both commands arrive in the same cycle, clear wins. Condition-flag updates never change control flags.
- R9: A full load writes all nine flags from the load word at the next edge and takes priority over an update strobe and over control commands in the same cycle.
- R10: The interrupt output equals the request input while interrupt-enable is 1 and is 0 while it is 0.
- R11: An update strobe with the reserved operation code 7 changes no flag.
- R12: Without an update, a load or a command, the flags word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd | input | 1 | Update condition flags from the current operation |
| op | input | 3 | Operation code (R3) |
| wide | input | 1 | Operand size: 0 byte, 1 word |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| res | input | 16 | Raw result |
| res_carry | input | 1 | Carry out (add) or borrow out (subtract) at the selected size |
| dir_set | input | 1 | Set direction flag |
| dir_clr | input | 1 | Clear direction flag |
| ien_set | input | 1 | Set interrupt-enable flag |
| ien_clr | input | 1 | Clear interrupt-enable flag |
| trp_set | input | 1 | Set trap flag |
| trp_clr | input | 1 | Clear trap flag |
| ld | input | 1 | Load the whole flags word |
| ld_word | input | 16 | Value for a full load |
| irq_req | input | 1 | Maskable interrupt request |
| flags_q | output | 16 | Flags word |
| cf | output | 1 | Carry flag |
| pf | output | 1 | Parity flag |
| af | output | 1 | Auxiliary carry flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| of | output | 1 | Overflow flag |
| df | output | 1 | Direction flag |
| ief | output | 1 | Interrupt-enable flag |
| tf | output | 1 | Trap flag |
| irq_take | output | 1 | Gated interrupt request |

## Verification
The assertions check several rules on every cycle. Increment and decrement keep the carry flag. Logical operations clear carry and overflow. Zero and sign are never both set after an update. Idle cycles leave the word unchanged. Set commands, and clear-wins on a set/clear clash, act on the control flags, which an update never touches. The exact values of each flag for given operand and result patterns can only be shown by the bench's vectors. The same holds for the byte/word choice of the sign and zero bits, parity confined to the low byte, the nibble carry, the masking of bits on a full load and the reserved operation code.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int unsigned FW      = 16;
  localparam int unsigned POS_C   = 0;
  localparam int unsigned POS_ONE = 1;
  localparam int unsigned POS_P   = 2;
  localparam int unsigned POS_A   = 4;
  localparam int unsigned POS_Z   = 6;
  localparam int unsigned POS_S   = 7;
  localparam int unsigned POS_T   = 8;
  localparam int unsigned POS_I   = 9;
  localparam int unsigned POS_D   = 10;
  localparam int unsigned POS_O   = 11;
  localparam int unsigned NIB_BIT = 4;
  localparam int unsigned PAR_W   = 8;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_INC = 3'd5,
    OP_DEC = 3'd6,
    OP_RSV = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic p;
    logic a;
    logic z;
    logic s;
    logic o;
  } cond_t;

  typedef struct packed {
    logic d;
    logic i;
    logic t;
  } ctrl_t;
endpackage

// File: rtl/flag_rst_sync.sv
module flag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/flag_cond_calc.sv
module flag_cond_calc
  import alu_flag_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [2:0]    op,
  input  logic          wide,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [DW-1:0] res,
  input  logic          res_carry,
  output cond_t         cond_nxt,
  output logic          cond_we,
  output logic          carry_we
);
  localparam int unsigned HW = DW / 2;

  logic [DW-1:0] b_eff;
  logic          a_msb, b_msb, r_msb;
  logic          is_arith, is_logic, is_step, is_minus;
  logic          ovf_add, ovf_sub;
  logic          zero_b, zero_w;

  always_comb begin
    is_arith = (op == OP_ADD) || (op == OP_SUB);
    is_step  = (op == OP_INC) || (op == OP_DEC);
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    is_minus = (op == OP_SUB) || (op == OP_DEC);
    b_eff    = is_step ? DW'(1) : opnd_b;
    a_msb    = wide ? opnd_a[DW-1] : opnd_a[HW-1];
    b_msb    = wide ? b_eff[DW-1]  : b_eff[HW-1];
    r_msb    = wide ? res[DW-1]    : res[HW-1];
    zero_b   = (res[HW-1:0] == '0);
    zero_w   = (res == '0);
    ovf_add  = (a_msb == b_msb) && (r_msb != a_msb);
    ovf_sub  = (a_msb != b_msb) && (r_msb != a_msb);
  end

  always_comb begin
    cond_nxt.p = ~(^res[PAR_W-1:0]);
    cond_nxt.z = wide ? zero_w : zero_b;
    cond_nxt.s = r_msb;
    if (is_logic) begin
      cond_nxt.c = 1'b0;
      cond_nxt.a = 1'b0;
      cond_nxt.o = 1'b0;
    end else begin
      cond_nxt.c = res_carry;
      cond_nxt.a = opnd_a[NIB_BIT] ^ b_eff[NIB_BIT] ^ res[NIB_BIT];
      cond_nxt.o = is_minus ? ovf_sub : ovf_add;
    end
    cond_we  = is_arith || is_step || is_logic;
    carry_we = is_arith || is_logic;
  end
endmodule

// File: rtl/flag_ctrl_bits.sv
module flag_ctrl_bits
  import alu_flag_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld,
  input  ctrl_t ld_val,
  input  ctrl_t set_cmd,
  input  ctrl_t clr_cmd,
  output ctrl_t ctrl_q
);
  ctrl_t ctrl_d;
  logic  ctrl_en;

  always_comb begin
    ctrl_en = ld || (|set_cmd) || (|clr_cmd);
    if (ld) ctrl_d = ld_val;
    else    ctrl_d = (ctrl_q | set_cmd) & ~clr_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // R8: a lone set command raises the direction flag
  p_dir_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cmd.d && !clr_cmd.d && !ld) |=> ctrl_q.d);

  // R8: clear wins over set for interrupt enable
  p_ien_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cmd.i && clr_cmd.i && !ld) |=> !ctrl_q.i);

  // R8: without commands or load the control flags hold
  p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && set_cmd == '0 && clr_cmd == '0) |=> $stable(ctrl_q));
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [2:0]    op,
  input  logic          wide,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [DW-1:0] res,
  input  logic          res_carry,
  input  logic          dir_set,
  input  logic          dir_clr,
  input  logic          ien_set,
  input  logic          ien_clr,
  input  logic          trp_set,
  input  logic          trp_clr,
  input  logic          ld,
  input  logic [FW-1:0] ld_word,
  input  logic          irq_req,
  output logic [FW-1:0] flags_q,
  output logic          cf,
  output logic          pf,
  output logic          af,
  output logic          zf,
  output logic          sf,
  output logic          of,
  output logic          df,
  output logic          ief,
  output logic          tf,
  output logic          irq_take
);
  logic  rst_n_s;
  cond_t cond_nxt, cond_q, cond_d;
  logic  cond_we, carry_we, cond_en;
  ctrl_t ctrl_q, ctrl_ld, ctrl_set, ctrl_clr;
  cond_t cond_ld;
  logic  any_cmd;

  flag_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_s)
  );

  flag_cond_calc #(.DW(DW)) i_cond_calc (
    .op       (op),
    .wide     (wide),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .res      (res),
    .res_carry(res_carry),
    .cond_nxt (cond_nxt),
    .cond_we  (cond_we),
    .carry_we (carry_we)
  );

  always_comb begin
    ctrl_ld  = '{d: ld_word[POS_D], i: ld_word[POS_I], t: ld_word[POS_T]};
    ctrl_set = '{d: dir_set, i: ien_set, t: trp_set};
    ctrl_clr = '{d: dir_clr, i: ien_clr, t: trp_clr};
    any_cmd  = (|ctrl_set) || (|ctrl_clr);
  end

  flag_ctrl_bits i_ctrl_bits (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ld     (ld),
    .ld_val (ctrl_ld),
    .set_cmd(ctrl_set),
    .clr_cmd(ctrl_clr),
    .ctrl_q (ctrl_q)
  );

  // next state of the condition flags
  always_comb begin
    cond_ld = '{c: ld_word[POS_C], p: ld_word[POS_P], a: ld_word[POS_A],
                z: ld_word[POS_Z], s: ld_word[POS_S], o: ld_word[POS_O]};
    cond_en = ld || (upd && cond_we);
    if (ld) begin
      cond_d = cond_ld;
    end else begin
      cond_d   = cond_nxt;
      cond_d.c = carry_we ? cond_nxt.c : cond_q.c;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     cond_q <= '0;
    else if (cond_en) cond_q <= cond_d;
  end

  always_comb begin
    flags_q          = '0;
    flags_q[POS_ONE] = 1'b1;
    flags_q[POS_C]   = cond_q.c;
    flags_q[POS_P]   = cond_q.p;
    flags_q[POS_A]   = cond_q.a;
    flags_q[POS_Z]   = cond_q.z;
    flags_q[POS_S]   = cond_q.s;
    flags_q[POS_O]   = cond_q.o;
    flags_q[POS_T]   = ctrl_q.t;
    flags_q[POS_I]   = ctrl_q.i;
    flags_q[POS_D]   = ctrl_q.d;
  end

  assign cf       = cond_q.c;
  assign pf       = cond_q.p;
  assign af       = cond_q.a;
  assign zf       = cond_q.z;
  assign sf       = cond_q.s;
  assign of       = cond_q.o;
  assign df       = ctrl_q.d;
  assign ief      = ctrl_q.i;
  assign tf       = ctrl_q.t;
  assign irq_take = irq_req && ctrl_q.i;

  // R3: increment and decrement keep the carry flag
  p_step_keeps_carry_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (upd && !ld && (op == OP_INC || op == OP_DEC)) |=> (cf == $past(cf)));

  // R7: logical operations clear carry and overflow
  p_logic_clears_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (upd && !ld && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> (!cf && !of));

  // R6: a freshly computed result is never both zero and negative
  p_zero_sign_excl_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (upd && !ld && op != OP_RSV) |=> !(zf && sf));

  // R8: updates leave the control flags alone
  p_upd_no_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (upd && !ld && !any_cmd) |=> $stable({df, ief, tf}));

  // R12: idle cycles hold the whole word
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!upd && !ld && !any_cmd) |=> $stable(flags_q));

  // R11: the reserved code changes nothing
  p_reserved_hold_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (upd && op == OP_RSV && !ld && !any_cmd) |=> $stable(flags_q));
endmodule

// File: tb/test_alu_flag_reg.sv
`timescale 1ns/1ps
module test_alu_flag_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd, wide, res_carry, ld, irq_req;
  logic [2:0]  op;
  logic [15:0] opnd_a, opnd_b, res, ld_word;
  logic        dir_set, dir_clr, ien_set, ien_clr, trp_set, trp_clr;
  logic [15:0] flags_q;
  logic        cf, pf, af, zf, sf, of, df, ief, tf, irq_take;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alu_flag_reg i_alu_flag_reg (
    .clk(clk), .rst_n(rst_n), .upd(upd), .op(op), .wide(wide),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res(res), .res_carry(res_carry),
    .dir_set(dir_set), .dir_clr(dir_clr), .ien_set(ien_set), .ien_clr(ien_clr),
    .trp_set(trp_set), .trp_clr(trp_clr), .ld(ld), .ld_word(ld_word),
    .irq_req(irq_req), .flags_q(flags_q), .cf(cf), .pf(pf), .af(af), .zf(zf),
    .sf(sf), .of(of), .df(df), .ief(ief), .tf(tf), .irq_take(irq_take)
  );

  // {op, wide, a, b, result, carry, expected flags word}
  localparam int NV = 12;
  localparam logic [68:0] VEC [NV] = '{
    {3'd0, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 16'h0896}, // R7 add ovf
    {3'd0, 1'b0, 16'h00FF, 16'h0001, 16'h1200, 1'b1, 16'h0057}, // R6 byte zero
    {3'd5, 1'b0, 16'h007F, 16'h0000, 16'h0080, 1'b0, 16'h0893}, // R3 inc keeps C
    {3'd1, 1'b1, 16'h0000, 16'h0001, 16'hFFFF, 1'b1, 16'h0097}, // R3 borrow
    {3'd2, 1'b1, 16'hF0F0, 16'h0F0F, 16'h0000, 1'b1, 16'h0046}, // R5 logic
    {3'd1, 1'b1, 16'h8000, 16'h0001, 16'h7FFF, 1'b0, 16'h0816}, // R7 sub ovf
    {3'd6, 1'b0, 16'h0000, 16'h0000, 16'h00FF, 1'b1, 16'h0096}, // R3 dec keeps C
    {3'd4, 1'b0, 16'h000F, 16'h0001, 16'h000E, 1'b0, 16'h0002}, // R4 odd
    {3'd3, 1'b1, 16'h8000, 16'h0003, 16'h8003, 1'b0, 16'h0086}, // R4 low byte
    {3'd7, 1'b1, 16'h1234, 16'h5678, 16'h0000, 1'b1, 16'h0086}, // R11 reserved
    {3'd0, 1'b1, 16'h8000, 16'h8000, 16'h0000, 1'b1, 16'h0847}, // R7 neg+neg
    {3'd0, 1'b0, 16'h0008, 16'h0008, 16'h0010, 1'b0, 16'h0012}  // R5 nibble
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    upd = 0; ld = 0; op = 3'd0; wide = 0; opnd_a = '0; opnd_b = '0; res = '0;
    res_carry = 0; ld_word = '0; irq_req = 0;
    dir_set = 0; dir_clr = 0; ien_set = 0; ien_clr = 0; trp_set = 0; trp_clr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 reset word", flags_q, 16'h0002);

    for (int k = 0; k < NV; k++) begin
      {op, wide, opnd_a, opnd_b, res, res_carry} = VEC[k][68:16];
      upd = 1;
      @(negedge clk);
      upd = 0;
      chk($sformatf("R3-R7 vector %0d", k), flags_q, VEC[k][15:0]);
    end

    // R12: idle holds
    repeat (3) @(negedge clk);
    chk("R12 idle hold", flags_q, 16'h0012);

    // R8: set commands
    dir_set = 1; ien_set = 1; trp_set = 1;
    @(negedge clk);
    dir_set = 0; ien_set = 0; trp_set = 0;
    chk("R8 set all control", flags_q, 16'h0712);

    // R10: interrupt passes while enabled
    irq_req = 1; #1;
    chk("R10 irq enabled", {15'd0, irq_take}, 16'h0001);

    // R8: update leaves control flags
    op = 3'd2; wide = 1; res = 16'h0001; upd = 1;
    @(negedge clk);
    upd = 0;
    chk("R8 update keeps control", flags_q, 16'h0702);

    // R8: set and clear together, clear wins
    ien_set = 1; ien_clr = 1;
    @(negedge clk);
    ien_set = 0; ien_clr = 0;
    chk("R8 clear wins", flags_q, 16'h0502);

    // R10: interrupt blocked
    #1;
    chk("R10 irq masked", {15'd0, irq_take}, 16'h0000);
    irq_req = 0;

    // R9 and R2: full load of all ones wins over update and command
    ld = 1; ld_word = 16'hFFFF; upd = 1; op = 3'd2; res = 16'h0000; dir_clr = 1;
    @(negedge clk);
    ld = 0; upd = 0; dir_clr = 0;
    chk("R9 R2 load ones masked", flags_q, 16'h0FD7);

    // R2: load of zero still shows bit 1
    ld = 1; ld_word = 16'h0000;
    @(negedge clk);
    ld = 0;
    chk("R2 load zeros", flags_q, 16'h0002);

    // R8: trap and direction clear individually
    trp_set = 1; dir_set = 1;
    @(negedge clk);
    trp_set = 0; dir_set = 0;
    trp_clr = 1;
    @(negedge clk);
    trp_clr = 0;
    chk("R8 trap clear", flags_q, 16'h0402);

    // R3: inc after load of carry keeps carry
    ld = 1; ld_word = 16'h0001;
    @(negedge clk);
    ld = 0;
    op = 3'd5; wide = 1; opnd_a = 16'h0001; res = 16'h0002; res_carry = 0; upd = 1;
    @(negedge clk);
    upd = 0;
    chk("R3 inc keeps loaded carry", flags_q, 16'h0003);

    // R1: asynchronous reset clears control and condition flags
    rst_n = 0;
    @(negedge clk);
    chk("R1 reset again", flags_q, 16'h0002);
    rst_n = 1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule